// File: doc/BRIEF.md
# Address Translation Window Table

This block translates inbound request addresses for a bus bridge. Software fills a small table of windows through a 32-bit register port. Each window has an enable bit, a power-of-two size and a source base, which is a 64-bit address aligned to its own size. It also has a translated base and a target identifier.

Every cycle a 64-bit request address is compared against all windows in parallel. The block picks the first enabled window whose region holds the address. It swaps the address bits above the window size for the window's translated base and reports the window's target identifier. The result is registered, so it appears one clock after the address.

Register reads are combinational from the register address. Writes take effect at the rising clock edge.

Top module: `atw_top`

## Requirements
- R1: The table holds 8 entries. Entry i starts at register byte address i*0x20. Within an entry the offsets are:
  - 0x0: source parameter
  - 0x4: source upper 32 bits
  - 0x8: translated base low 32 bits
  - 0xC: translated base upper 32 bits
  - 0x10: translation parameter
- R2: In the source parameter word:
  - bit 0 enables the window;
  - bits 6:1 hold the size code s, and the window spans 2^(s+1) bytes;
  - bits 31:12 hold source address bits 31:12;
  - bits 11:7 always read back as zero.
  - A disabled window never matches.
- R3: The translation parameter word keeps a 4-bit target ID in bits 3:0, and its bits 31:4 read as zero. Typical ID values are 4 for the first memory-mapped master port, 0 for the data transfer path and 1 for the configuration path. The ID is passed to the lookup output unchanged.
- R4: Offsets 0x14, 0x18 and 0x1C of an entry read as zero. Writes to those offsets change no register.
- R5: A request address matches an entry when the entry is enabled and request bits 63:s+1 equal the source address bits 63:s+1. The source address is {upper word, bits 31:12 of the parameter word, 12 zero bits}. A size code of 63 matches every address.
- R6: On a hit, the output address takes bits 63:s+1 from the translated base and bits s:0 from the request.
- R7: When several enabled windows match, the lowest-index entry provides the result.
- R8: When no window matches, the hit output is 0, the output address equals the request and the target ID is 0.
- R9: After reset every register reads zero and no address hits.
- R10: Lookup outputs change exactly one clock after the request address is presented. A register write made in the same cycle as a lookup affects only lookups presented in later cycles.
- R11: One enabled entry with source 0, translated base 0 and size code 31 maps every 32-bit address to itself and misses any address at or above 2^32.
- R12: Two adjacent 1 GiB windows (size code 29) work together. Source 0x80000000 translates to 0x0 and source 0xC0000000 translates to 0x40000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| regAddr | input | 8 | Register byte address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr |
| lkAddr | input | 64 | Request address to translate |
| lkHit | output | 1 | A window matched (registered) |
| lkOutAddr | output | 64 | Translated or passed-through address (registered) |
| lkTid | output | 4 | Target ID of the matching window, 0 on a miss (registered) |

## Verification
A register write and a lookup that hits the entry being written can land in the same clock. The bench provokes this by driving a write to the translated base of the hitting entry and a request address on the same cycle. It expects the registered result to carry the old base, and a repeat of the same lookup one cycle later to carry the new base. Overlapping windows and a window covering everything are also exercised, so that priority and the size code 63 edge are judged at the lookup outputs.

// File: rtl/atw_pkg.sv
package atw_pkg;
  localparam int NUM_WIN   = 8;
  localparam int ADDR_W    = 64;
  localparam int DATA_W    = 32;
  localparam int TID_W     = 4;
  localparam int SIZE_W    = 6;
  localparam int STRIDE    = 32;
  localparam int PAGE_BITS = 12;
  localparam int IDX_W     = $clog2(NUM_WIN);
  localparam int OFF_W     = $clog2(STRIDE);
  localparam int REG_AW    = IDX_W + OFF_W;
  localparam logic [DATA_W-1:0] SRC_PARAM_MASK =
    {{(DATA_W-PAGE_BITS){1'b1}}, {(PAGE_BITS-SIZE_W-1){1'b0}}, {(SIZE_W+1){1'b1}}};

  typedef enum logic [2:0] {
    FLD_SRC_PARAM = 3'd0,
    FLD_SRC_HI    = 3'd1,
    FLD_TR_LO     = 3'd2,
    FLD_TR_HI     = 3'd3,
    FLD_TR_PARAM  = 3'd4,
    FLD_NONE      = 3'd7
  } field_t;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic             srcParam;
    logic             srcHi;
    logic             trLo;
    logic             trHi;
    logic             trParam;
  } wrStrobe_t;
endpackage

// File: rtl/atw_ctrl.sv
module atw_ctrl
  import atw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  output wrStrobe_t         wrStb,
  output logic [IDX_W-1:0]  rdIdx,
  output field_t            rdFld
);
  logic [OFF_W-1:0] offset;
  field_t           fld;

  assign offset = regAddr[OFF_W-1:0];
  assign rdIdx  = regAddr[REG_AW-1:OFF_W];

  always_comb begin
    unique case (offset)
      OFF_W'(5'h00): fld = FLD_SRC_PARAM;
      OFF_W'(5'h04): fld = FLD_SRC_HI;
      OFF_W'(5'h08): fld = FLD_TR_LO;
      OFF_W'(5'h0C): fld = FLD_TR_HI;
      OFF_W'(5'h10): fld = FLD_TR_PARAM;
      default:       fld = FLD_NONE;
    endcase
  end

  assign rdFld = fld;

  always_comb begin
    wrStb          = '0;
    wrStb.idx      = rdIdx;
    wrStb.srcParam = regWrEn && (fld == FLD_SRC_PARAM);
    wrStb.srcHi    = regWrEn && (fld == FLD_SRC_HI);
    wrStb.trLo     = regWrEn && (fld == FLD_TR_LO);
    wrStb.trHi     = regWrEn && (fld == FLD_TR_HI);
    wrStb.trParam  = regWrEn && (fld == FLD_TR_PARAM);
  end

  // R1: one register of one entry at most is written per cycle
  assert_strobe_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wrStb.srcParam, wrStb.srcHi, wrStb.trLo, wrStb.trHi, wrStb.trParam}));
endmodule

// File: rtl/atw_table.sv
module atw_table
  import atw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  wrStrobe_t         wrStb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdx,
  input  field_t            rdFld,
  output logic [DATA_W-1:0] rdData,
  input  logic [ADDR_W-1:0] lkAddr,
  output logic              lkHit,
  output logic [ADDR_W-1:0] lkOutAddr,
  output logic [TID_W-1:0]  lkTid
);
  logic [DATA_W-1:0] srcLoQ [NUM_WIN];
  logic [DATA_W-1:0] srcHiQ [NUM_WIN];
  logic [DATA_W-1:0] trLoQ  [NUM_WIN];
  logic [DATA_W-1:0] trHiQ  [NUM_WIN];
  logic [TID_W-1:0]  tidQ   [NUM_WIN];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_WIN; i++) begin
        srcLoQ[i] <= '0;
        srcHiQ[i] <= '0;
        trLoQ[i]  <= '0;
        trHiQ[i]  <= '0;
        tidQ[i]   <= '0;
      end
    end else begin
      if (wrStb.srcParam) srcLoQ[wrStb.idx] <= wrData & SRC_PARAM_MASK;
      if (wrStb.srcHi)    srcHiQ[wrStb.idx] <= wrData;
      if (wrStb.trLo)     trLoQ[wrStb.idx]  <= wrData;
      if (wrStb.trHi)     trHiQ[wrStb.idx]  <= wrData;
      if (wrStb.trParam)  tidQ[wrStb.idx]   <= wrData[TID_W-1:0];
    end
  end

  always_comb begin
    unique case (rdFld)
      FLD_SRC_PARAM: rdData = srcLoQ[rdIdx];
      FLD_SRC_HI:    rdData = srcHiQ[rdIdx];
      FLD_TR_LO:     rdData = trLoQ[rdIdx];
      FLD_TR_HI:     rdData = trHiQ[rdIdx];
      FLD_TR_PARAM:  rdData = {{(DATA_W-TID_W){1'b0}}, tidQ[rdIdx]};
      default:       rdData = '0;
    endcase
  end

  logic [NUM_WIN-1:0] matchVec;
  logic [ADDR_W-1:0]  xlat [NUM_WIN];

  for (genvar g = 0; g < NUM_WIN; g++) begin : gWin
    logic [SIZE_W-1:0] sizeCode;
    logic [ADDR_W-1:0] lowMask;
    logic [ADDR_W-1:0] srcBase;
    logic [ADDR_W-1:0] trBase;

    assign sizeCode = srcLoQ[g][SIZE_W:1];
    assign srcBase  = {srcHiQ[g], srcLoQ[g][DATA_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
    assign trBase   = {trHiQ[g], trLoQ[g]};

    always_comb begin
      if (sizeCode == {SIZE_W{1'b1}}) lowMask = '1;
      else lowMask = (ADDR_W'(1) << (ADDR_W'(sizeCode) + ADDR_W'(1))) - ADDR_W'(1);
    end

    assign matchVec[g] = srcLoQ[g][0] && ((lkAddr & ~lowMask) == (srcBase & ~lowMask));
    assign xlat[g]     = (trBase & ~lowMask) | (lkAddr & lowMask);
  end

  logic              selHit;
  logic [ADDR_W-1:0] selAddr;
  logic [TID_W-1:0]  selTid;

  always_comb begin
    selHit  = 1'b0;
    selAddr = lkAddr;
    selTid  = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        selHit  = 1'b1;
        selAddr = xlat[i];
        selTid  = tidQ[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lkHit     <= 1'b0;
      lkOutAddr <= '0;
      lkTid     <= '0;
    end else begin
      lkHit     <= selHit;
      lkOutAddr <= selAddr;
      lkTid     <= selTid;
    end
  end

  // R8: a miss passes the previous cycle's request through with ID 0
  assert_miss_passthru_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !lkHit) |-> (lkOutAddr == $past(lkAddr) && lkTid == '0));

  // R6: every window is at least two bytes, so bit 0 always comes from the request
  assert_low_bit_kept_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && lkHit) |-> (lkOutAddr[0] == $past(lkAddr[0])));

  // R9: the first result after reset is a miss
  assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !lkHit);
endmodule

// File: rtl/atw_top.sv
module atw_top
  import atw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [63:0]       lkAddr,
  output logic              lkHit,
  output logic [63:0]       lkOutAddr,
  output logic [3:0]        lkTid
);
  wrStrobe_t        wrStb;
  logic [IDX_W-1:0] rdIdx;
  field_t           rdFld;

  atw_ctrl uCtrl (
    .clk     (clk),
    .rst     (rst),
    .regAddr (regAddr[REG_AW-1:0]),
    .regWrEn (regWrEn),
    .wrStb   (wrStb),
    .rdIdx   (rdIdx),
    .rdFld   (rdFld)
  );

  atw_table uTable (
    .clk       (clk),
    .rst       (rst),
    .wrStb     (wrStb),
    .wrData    (regWrData),
    .rdIdx     (rdIdx),
    .rdFld     (rdFld),
    .rdData    (regRdData),
    .lkAddr    (lkAddr),
    .lkHit     (lkHit),
    .lkOutAddr (lkOutAddr),
    .lkTid     (lkTid)
  );
endmodule

// File: tb/sim_atw_top.sv
`timescale 1ns/1ps
module sim_atw_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  regAddr;
  logic        regWrEn;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic [63:0] lkAddr;
  logic        lkHit;
  logic [63:0] lkOutAddr;
  logic [3:0]  lkTid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  atw_top u0 (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .lkAddr(lkAddr),
    .lkHit(lkHit), .lkOutAddr(lkOutAddr), .lkTid(lkTid)
  );

  typedef struct packed {
    logic [63:0] a;
    logic        h;
    logic [63:0] o;
    logic [3:0]  t;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{64'h0000_0000_8000_0000, 1'b1, 64'h0000_0000_0000_0000, 4'd4},
    '{64'h0000_0000_BFFF_FFFF, 1'b1, 64'h0000_0000_3FFF_FFFF, 4'd4},
    '{64'h0000_0000_C000_1234, 1'b1, 64'h0000_0000_4000_1234, 4'd4},
    '{64'h0000_0000_FFFF_FFFF, 1'b1, 64'h0000_0000_7FFF_FFFF, 4'd4},
    '{64'h0000_0000_7FFF_FFFF, 1'b0, 64'h0000_0000_7FFF_FFFF, 4'd0},
    '{64'h0000_0001_0000_0010, 1'b1, 64'h0000_0012_3456_7010, 4'd1},
    '{64'h0000_0001_0000_2345, 1'b1, 64'h0000_0000_9000_2345, 4'd0},
    '{64'h0000_0001_0001_0000, 1'b0, 64'h0000_0001_0001_0000, 4'd0},
    '{64'h0000_0000_2000_0100, 1'b0, 64'h0000_0000_2000_0100, 4'd0},
    '{64'h0000_0001_8000_0000, 1'b0, 64'h0000_0001_8000_0000, 4'd0}
  };

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    regAddr = a;
    #1;
    checks++;
    if (regRdData !== exp) begin
      errors++;
      $display("FAIL %s read 0x%02h actual 0x%08h expected 0x%08h", tag, a, regRdData, exp);
    end
  endtask

  task automatic lkCmp(input logic h, input logic [63:0] o, input logic [3:0] t, input string tag);
    checks++;
    if (lkHit !== h || lkOutAddr !== o || lkTid !== t) begin
      errors++;
      $display("FAIL %s actual hit %0b addr 0x%016h tid %0d expected hit %0b addr 0x%016h tid %0d",
               tag, lkHit, lkOutAddr, lkTid, h, o, t);
    end
  endtask

  task automatic lkChk(input logic [63:0] a, input logic h, input logic [63:0] o,
                       input logic [3:0] t, input string tag);
    @(negedge clk);
    lkAddr = a;
    @(negedge clk);
    lkCmp(h, o, t, tag);
  endtask

  task automatic progEntry(input int i, input logic [31:0] sp, input logic [31:0] sh,
                           input logic [31:0] tl, input logic [31:0] th, input logic [31:0] tp);
    wrReg(8'(i*32 + 0),  sp);
    wrReg(8'(i*32 + 4),  sh);
    wrReg(8'(i*32 + 8),  tl);
    wrReg(8'(i*32 + 12), th);
    wrReg(8'(i*32 + 16), tp);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    rst = 1'b1; regAddr = '0; regWrEn = 1'b0; regWrData = '0; lkAddr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R9: registers cleared, lookup misses
    rdChk(8'h00, 32'h0, "R9 src param e0");
    rdChk(8'hE8, 32'h0, "R9 tr low e7");
    lkChk(64'h0, 1'b0, 64'h0, 4'd0, "R9 lookup after reset");

    // table set: two 1 GiB windows, overlapping pair, disabled entry
    progEntry(0, 32'h8000_003B, 32'h0, 32'h0,         32'h0,  32'h4);
    progEntry(1, 32'hC000_003B, 32'h0, 32'h4000_0000, 32'h0,  32'h4);
    progEntry(2, 32'h0000_0017, 32'h1, 32'h3456_7000, 32'h12, 32'h1);
    progEntry(3, 32'h0000_001F, 32'h1, 32'h9000_0000, 32'h0,  32'h0);
    progEntry(4, 32'h2000_0028, 32'h0, 32'h5555_0000, 32'h0,  32'h1);

    // R5 R6 R7 R8 R12 R2: vector walk
    for (int v = 0; v < 10; v++) begin
      lkChk(VECS[v].a, VECS[v].h, VECS[v].o, VECS[v].t,
            $sformatf("R5 R6 R7 R8 R12 vector %0d", v));
    end

    // R10: output holds until the next edge after a new address
    @(negedge clk);
    lkAddr = 64'h0000_0000_8000_0010;
    #1;
    lkCmp(1'b0, 64'h0000_0001_8000_0000, 4'd0, "R10 no change before edge");
    @(negedge clk);
    lkCmp(1'b1, 64'h0000_0000_0000_0010, 4'd4, "R10 change after one edge");

    // R2: reserved bits read zero; size code 63 covers all
    wrReg(8'hA0, 32'hFFFF_FFFF);
    rdChk(8'hA0, 32'hFFFF_F07F, "R2 src param readback");
    // R3: target ID keeps 4 bits
    wrReg(8'hB0, 32'hFFFF_FFF7);
    rdChk(8'hB0, 32'h0000_0007, "R3 tr param readback");
    lkChk(64'h0000_0000_7FFF_FFFF, 1'b1, 64'h0000_0000_7FFF_FFFF, 4'd7, "R5 size 63 window");
    lkChk(64'h0000_0001_0000_0010, 1'b1, 64'h0000_0012_3456_7010, 4'd1, "R7 lower index wins");

    // R4: unused offsets
    wrReg(8'h14, 32'hFFFF_FFFF);
    rdChk(8'h14, 32'h0, "R4 unused read");
    rdChk(8'h1C, 32'h0, "R4 unused read 0x1C");
    rdChk(8'h00, 32'h8000_003B, "R4 neighbour untouched");
    rdChk(8'h10, 32'h0000_0004, "R4 tr param untouched");

    // R9: reset clears again
    doReset();
    rdChk(8'hA0, 32'h0, "R9 src param e5 after reset");
    lkChk(64'h0000_0000_7FFF_FFFF, 1'b0, 64'h0000_0000_7FFF_FFFF, 4'd0, "R9 miss after reset");

    // R11: identity over 4 GiB
    progEntry(0, 32'h0000_003F, 32'h0, 32'h0, 32'h0, 32'h4);
    lkChk(64'h0000_0000_DEAD_BEEF, 1'b1, 64'h0000_0000_DEAD_BEEF, 4'd4, "R11 identity");
    lkChk(64'h0000_0000_0000_0000, 1'b1, 64'h0000_0000_0000_0000, 4'd4, "R11 identity zero");
    lkChk(64'h0000_0001_0000_0000, 1'b0, 64'h0000_0001_0000_0000, 4'd0, "R11 above 4 GiB");

    // R10: write and hitting lookup in the same cycle
    @(negedge clk);
    regAddr = 8'h0C; regWrData = 32'h5; regWrEn = 1'b1;
    lkAddr = 64'h0000_0000_0000_1234;
    @(negedge clk);
    regWrEn = 1'b0;
    lkCmp(1'b1, 64'h0000_0000_0000_1234, 4'd4, "R10 same-cycle write uses old base");
    @(negedge clk);
    lkCmp(1'b1, 64'h0000_0005_0000_1234, 4'd4, "R10 next lookup uses new base");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule